// File: doc/BRIEF.md
# Request/Reply Network Input Sink

This block is the receive stage of a node on a network that carries two classes of transaction: requests, which may cause the local handler to send a response, and replies to requests the node issued earlier. The input channel has no ready signal, so the node takes every transaction in the cycle it arrives. Two independent queues hold the arrivals, one for each class. A reply never waits behind a request. Replies can therefore always drain, even when the node cannot send anything.

Space in the request queue is reserved per remote source. Each of the `N_SRC` remote nodes may have up to `K_OUT` requests waiting. If a request arrives from a source whose share is used up, or from a source number outside the configured range, the block does not stall the network. It refuses the request and sends a NACK that names the requester and the request tag. The reply queue holds `K_OUT` entries, which matches the node's own limit on outstanding requests.

The local handler receives a request only when the outbound response path reports a free slot. Answering a request therefore never blocks the input.

Top module: `reqrep_sink`

## Requirements
- R1: The input channel has no back-pressure. A reply presented while the request side is blocked (request queue stalled, outbound slot busy) is still delivered on the reply output.
- R2: `in_class_i` = 0 marks a request and 1 marks a reply. Admitted requests leave the request output in arrival order, carrying the same source, tag and data.
- R3: `rep_valid_o` is high exactly when the reply queue holds an entry. Replies leave in arrival order. `rsp_slot_free_i` and the request queue have no effect on the reply output.
- R4: A request is admitted only when its source number is below `N_SRC` and that source has fewer than `K_OUT` requests queued. Any other request is refused.
- R5: A refused request raises `nack_valid_o` for exactly one cycle, in the cycle after it was presented. `nack_src_o` and `nack_tag_o` carry the source and tag of the refused request. `nack_valid_o` is never high at any other time.
- R6: When the handler accepts a request (`req_valid_o` and `req_ready_i` both high), one unit of that source's reservation is freed. A later request from that source is then admitted.
- R7: `req_valid_o` is high only when the request queue is not empty and `rsp_slot_free_i` is high. `req_ready_i` has no effect while `req_valid_o` is low.
- R8: The request queue never holds more than `K_OUT*N_SRC` entries, and no source ever holds more than `K_OUT`. When every reservation is full, each new request is refused.
- R9: After reset both queues are empty, and `req_valid_o`, `rep_valid_o` and `nack_valid_o` are low.
- R10: Admission uses the occupancy held at the start of the cycle. A request from a full source is refused even if one of that source's requests leaves in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Network transaction present |
| in_class_i | input | 1 | 0 request, 1 reply |
| in_src_i | input | SRC_W | Sending node number |
| in_tag_i | input | TAG_W | Transaction tag |
| in_data_i | input | DATA_W | Payload |
| rsp_slot_free_i | input | 1 | Outbound response path can take one more entry |
| req_ready_i | input | 1 | Handler takes the head request |
| req_valid_o | output | 1 | Head request offered to the handler |
| req_src_o | output | SRC_W | Source of head request |
| req_tag_o | output | TAG_W | Tag of head request |
| req_data_o | output | DATA_W | Payload of head request |
| rep_ready_i | input | 1 | Handler takes the head reply |
| rep_valid_o | output | 1 | Head reply offered |
| rep_src_o | output | SRC_W | Source of head reply |
| rep_tag_o | output | TAG_W | Tag of head reply |
| rep_data_o | output | DATA_W | Payload of head reply |
| nack_valid_o | output | 1 | Refusal notice, one-cycle pulse |
| nack_src_o | output | SRC_W | Source of refused request |
| nack_tag_o | output | TAG_W | Tag of refused request |

## Verification
The checker evaluates several properties on every cycle:
- No source's occupancy goes above `K_OUT`.
- The request queue's occupancy equals the sum of the per-source counts.
- A request is offered only while the outbound slot is free.
- Every NACK follows a request and carries that request's source and tag.
- A request from a full source is always followed by a NACK.
- No reply arrives while the reply queue is full.

Some behaviour cannot be shown by a single-cycle property and is left to the bench scenarios:
- ordering within each queue, checked against a scoreboard;
- replies draining while requests are held back;
- a reservation unit being reused after a pop;
- refusal when a pop from a full source and a new request from that source fall in the same cycle;
- refusal of an out-of-range source number.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_REP = 1'b1
  } msg_cls_e;
endpackage

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rr_src_credits.sv
module rr_src_credits #(
  parameter int N_SRC = 3,
  parameter int K_OUT = 2,
  parameter int SRC_W = 2,
  localparam int CNT_W = $clog2(K_OUT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SRC_W-1:0]       chk_src_i,
  output logic                   ok_o,
  input  logic                   take_i,
  input  logic                   rel_i,
  input  logic [SRC_W-1:0]       rel_src_i,
  output logic [N_SRC*CNT_W-1:0] cnt_flat_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [CNT_W-1:0] c_q;
    logic take_hit, rel_hit;
    assign take_hit = take_i && (chk_src_i == SRC_W'(s));
    assign rel_hit  = rel_i && (rel_src_i == SRC_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 c_q <= '0;
      else if (take_hit && !rel_hit) c_q <= c_q + 1'b1;
      else if (rel_hit && !take_hit) c_q <= c_q - 1'b1;
    end
    assign cnt_flat_o[s*CNT_W +: CNT_W] = c_q;
  end

  // out-of-range source numbers never match, so they are refused
  always_comb begin
    ok_o = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (chk_src_i == SRC_W'(s))
        ok_o = (cnt_flat_o[s*CNT_W +: CNT_W] < CNT_W'(K_OUT));
    end
  end
endmodule

// File: rtl/reqrep_sink.sv
module reqrep_sink #(
  parameter int N_SRC  = 3,
  parameter int K_OUT  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_class_i,
  input  logic [SRC_W-1:0]  in_src_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              rsp_slot_free_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [SRC_W-1:0]  req_src_o,
  output logic [TAG_W-1:0]  req_tag_o,
  output logic [DATA_W-1:0] req_data_o,
  input  logic              rep_ready_i,
  output logic              rep_valid_o,
  output logic [SRC_W-1:0]  rep_src_o,
  output logic [TAG_W-1:0]  rep_tag_o,
  output logic [DATA_W-1:0] rep_data_o,
  output logic              nack_valid_o,
  output logic [SRC_W-1:0]  nack_src_o,
  output logic [TAG_W-1:0]  nack_tag_o
);
  import rr_pkg::*;

  localparam int REQ_DEPTH = K_OUT * N_SRC;
  localparam int REP_DEPTH = K_OUT;
  localparam int ITEM_W    = SRC_W + TAG_W + DATA_W;
  localparam int REQ_CW    = $clog2(REQ_DEPTH + 1);
  localparam int REP_CW    = $clog2(REP_DEPTH + 1);
  localparam int CRD_W     = $clog2(K_OUT + 1);

  logic is_req, is_rep, credit_ok, admit, refuse;
  logic [ITEM_W-1:0] in_item, req_item, rep_item;
  logic req_empty, req_full, rep_empty, rep_full;
  logic req_pop, rep_pop;
  logic [REQ_CW-1:0] req_count;
  logic [REP_CW-1:0] rep_count;
  logic [N_SRC*CRD_W-1:0] src_cnt_flat;

  assign is_req  = in_valid_i && (msg_cls_e'(in_class_i) == CLS_REQ);
  assign is_rep  = in_valid_i && (msg_cls_e'(in_class_i) == CLS_REP);
  assign admit   = is_req && credit_ok;
  assign refuse  = is_req && !credit_ok;
  assign in_item = {in_src_i, in_tag_i, in_data_i};

  rr_src_credits #(.N_SRC(N_SRC), .K_OUT(K_OUT), .SRC_W(SRC_W)) u_credits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_src_i  (in_src_i),
    .ok_o       (credit_ok),
    .take_i     (admit),
    .rel_i      (req_pop),
    .rel_src_i  (req_src_o),
    .cnt_flat_o (src_cnt_flat)
  );

  rr_fifo #(.WIDTH(ITEM_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (admit),
    .din_i   (in_item),
    .pop_i   (req_pop),
    .dout_o  (req_item),
    .empty_o (req_empty),
    .full_o  (req_full),
    .count_o (req_count)
  );

  rr_fifo #(.WIDTH(ITEM_W), .DEPTH(REP_DEPTH)) u_rep_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (is_rep),
    .din_i   (in_item),
    .pop_i   (rep_pop),
    .dout_o  (rep_item),
    .empty_o (rep_empty),
    .full_o  (rep_full),
    .count_o (rep_count)
  );

  // offer a request only if its response has somewhere to go
  assign req_valid_o = !req_empty && rsp_slot_free_i;
  assign req_pop     = req_valid_o && req_ready_i;
  assign {req_src_o, req_tag_o, req_data_o} = req_item;

  assign rep_valid_o = !rep_empty;
  assign rep_pop     = rep_valid_o && rep_ready_i;
  assign {rep_src_o, rep_tag_o, rep_data_o} = rep_item;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nack_valid_o <= 1'b0;
      nack_src_o   <= '0;
      nack_tag_o   <= '0;
    end else begin
      nack_valid_o <= refuse;
      if (refuse) begin
        nack_src_o <= in_src_i;
        nack_tag_o <= in_tag_i;
      end
    end
  end
endmodule

// File: rtl/rr_sink_chk.sv
module rr_sink_chk #(
  parameter int N_SRC = 3,
  parameter int K_OUT = 2,
  parameter int TAG_W = 4,
  parameter int SRC_W = 2,
  localparam int REQ_CW = $clog2(K_OUT * N_SRC + 1),
  localparam int CRD_W  = $clog2(K_OUT + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   in_valid_i,
  input logic                   in_class_i,
  input logic [SRC_W-1:0]       in_src_i,
  input logic [TAG_W-1:0]       in_tag_i,
  input logic                   rsp_slot_free_i,
  input logic                   req_valid_o,
  input logic                   nack_valid_o,
  input logic [SRC_W-1:0]       nack_src_o,
  input logic [TAG_W-1:0]       nack_tag_o,
  input logic                   rep_full,
  input logic [REQ_CW-1:0]      req_count,
  input logic [N_SRC*CRD_W-1:0] src_cnt_flat
);
  int  cnt_sum;
  logic src_full;

  always_comb begin
    cnt_sum  = 0;
    src_full = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      cnt_sum = cnt_sum + int'(src_cnt_flat[s*CRD_W +: CRD_W]);
      if (in_src_i == SRC_W'(s))
        src_full = (src_cnt_flat[s*CRD_W +: CRD_W] == CRD_W'(K_OUT));
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_cap
    // R8
    src_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_cnt_flat[s*CRD_W +: CRD_W] <= CRD_W'(K_OUT));
  end

  // R6
  credit_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(req_count) == cnt_sum);

  // R1
  rep_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_class_i == rr_pkg::CLS_REP) |-> !rep_full);

  // R7
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> rsp_slot_free_i);

  // R5
  nack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_valid_o |-> $past(in_valid_i && in_class_i == rr_pkg::CLS_REQ));

  // R5
  nack_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_valid_o |-> (nack_src_o == $past(in_src_i) && nack_tag_o == $past(in_tag_i)));

  // R4
  full_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_class_i == rr_pkg::CLS_REQ && src_full) |=> nack_valid_o);
endmodule

bind reqrep_sink rr_sink_chk #(
  .N_SRC(N_SRC), .K_OUT(K_OUT), .TAG_W(TAG_W), .SRC_W(SRC_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .in_class_i      (in_class_i),
  .in_src_i        (in_src_i),
  .in_tag_i        (in_tag_i),
  .rsp_slot_free_i (rsp_slot_free_i),
  .req_valid_o     (req_valid_o),
  .nack_valid_o    (nack_valid_o),
  .nack_src_o      (nack_src_o),
  .nack_tag_o      (nack_tag_o),
  .rep_full        (rep_full),
  .req_count       (req_count),
  .src_cnt_flat    (src_cnt_flat)
);

// File: tb/reqrep_sink_test.sv
module reqrep_sink_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 3;
  localparam int K_OUT  = 2;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;
  localparam int SRC_W  = 2;
  localparam int ITEM_W = SRC_W + TAG_W + DATA_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_class_i = 1'b0;
  logic [SRC_W-1:0] in_src_i = '0;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic rsp_slot_free_i = 1'b0, req_ready_i = 1'b0, rep_ready_i = 1'b0;
  logic req_valid_o, rep_valid_o, nack_valid_o;
  logic [SRC_W-1:0] req_src_o, rep_src_o, nack_src_o;
  logic [TAG_W-1:0] req_tag_o, rep_tag_o, nack_tag_o;
  logic [DATA_W-1:0] req_data_o, rep_data_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reqrep_sink #(.N_SRC(N_SRC), .K_OUT(K_OUT), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_class_i(in_class_i), .in_src_i(in_src_i),
    .in_tag_i(in_tag_i), .in_data_i(in_data_i),
    .rsp_slot_free_i(rsp_slot_free_i), .req_ready_i(req_ready_i),
    .req_valid_o(req_valid_o), .req_src_o(req_src_o), .req_tag_o(req_tag_o),
    .req_data_o(req_data_o),
    .rep_ready_i(rep_ready_i), .rep_valid_o(rep_valid_o), .rep_src_o(rep_src_o),
    .rep_tag_o(rep_tag_o), .rep_data_o(rep_data_o),
    .nack_valid_o(nack_valid_o), .nack_src_o(nack_src_o), .nack_tag_o(nack_tag_o)
  );

  typedef logic [ITEM_W-1:0] item_t;
  item_t exp_req[$];
  item_t exp_rep[$];
  int  mcnt[N_SRC];
  bit  nack_pend = 1'b0;
  int  nack_src_e = 0, nack_tag_e = 0;
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle, compare outputs against the scoreboard, then update the model
  task automatic step(input bit v, input bit cls, input int src, input int tag,
                      input bit rq_rdy, input bit rp_rdy, input bit free, input string why);
    bit exp_rv, acc;
    @(negedge clk);
    in_valid_i = v; in_class_i = cls;
    in_src_i = SRC_W'(src); in_tag_i = TAG_W'(tag); in_data_i = DATA_W'(16'h1000 + tag);
    req_ready_i = rq_rdy; rep_ready_i = rp_rdy; rsp_slot_free_i = free;
    #1;
    // monitor
    exp_rv = (exp_req.size() > 0) && free;
    chk(req_valid_o === exp_rv, "R7", "req_valid", req_valid_o, exp_rv);
    if (exp_rv && req_valid_o)
      chk({req_src_o, req_tag_o, req_data_o} === exp_req[0], "R2", "req item",
          {req_src_o, req_tag_o, req_data_o}, exp_req[0]);
    chk(rep_valid_o === (exp_rep.size() > 0), "R3", "rep_valid", rep_valid_o, exp_rep.size() > 0);
    if (exp_rep.size() > 0 && rep_valid_o)
      chk({rep_src_o, rep_tag_o, rep_data_o} === exp_rep[0], "R3", "rep item",
          {rep_src_o, rep_tag_o, rep_data_o}, exp_rep[0]);
    chk(nack_valid_o === nack_pend, why, "nack_valid", nack_valid_o, nack_pend);
    if (nack_pend && nack_valid_o)
      chk(nack_src_o == SRC_W'(nack_src_e) && nack_tag_o == TAG_W'(nack_tag_e), why,
          "nack id", {nack_src_o, nack_tag_o}, {SRC_W'(nack_src_e), TAG_W'(nack_tag_e)});
    // model: admission sees occupancy before this cycle's pop
    acc = v && !cls && (src < N_SRC) && (mcnt[src % N_SRC] < K_OUT);
    nack_pend  = v && !cls && !acc;
    nack_src_e = src; nack_tag_e = tag;
    if (exp_rv && rq_rdy) begin
      mcnt[int'(exp_req[0][ITEM_W-1 -: SRC_W])]--;
      void'(exp_req.pop_front());
    end
    if (exp_rep.size() > 0 && rp_rdy) void'(exp_rep.pop_front());
    if (acc) begin
      mcnt[src]++;
      exp_req.push_back({SRC_W'(src), TAG_W'(tag), DATA_W'(16'h1000 + tag)});
    end
    if (v && cls) exp_rep.push_back({SRC_W'(src), TAG_W'(tag), DATA_W'(16'h1000 + tag)});
  endtask

  task automatic idle(input int n, input bit rq_rdy, input bit rp_rdy, input bit free,
                      input string why);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, rq_rdy, rp_rdy, free, why);
  endtask

  initial begin
    for (int s = 0; s < N_SRC; s++) mcnt[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rsp_slot_free_i = 1'b1; req_ready_i = 1'b1; rep_ready_i = 1'b1;
    #1;
    // R9 reset state
    chk(req_valid_o === 1'b0, "R9", "req_valid in reset", req_valid_o, 0);
    chk(rep_valid_o === 1'b0, "R9", "rep_valid in reset", rep_valid_o, 0);
    chk(nack_valid_o === 1'b0, "R9", "nack in reset", nack_valid_o, 0);
    rst_ni = 1'b1;
    idle(2, 1, 1, 1, "R9");

    // R2 order across sources
    step(1, 0, 0, 1, 0, 0, 1, "R2");
    step(1, 0, 1, 2, 0, 0, 1, "R2");
    step(1, 0, 2, 3, 0, 0, 1, "R2");
    idle(4, 1, 0, 1, "R2");

    // R4 per-source share, R5 nack contents
    step(1, 0, 0, 4, 0, 0, 1, "R4");
    step(1, 0, 0, 5, 0, 0, 1, "R4");
    step(1, 0, 0, 6, 0, 0, 1, "R4");
    step(1, 0, 1, 7, 0, 0, 1, "R5");
    idle(1, 0, 0, 1, "R5");

    // R1 / R7: replies drain while requests are held back
    step(1, 1, 2, 8, 1, 0, 0, "R1");
    step(1, 1, 2, 9, 1, 0, 0, "R1");
    step(1, 0, 2, 10, 1, 0, 0, "R7");
    idle(3, 1, 1, 0, "R1");

    // R10 pop and new request of a full source in one cycle
    step(1, 0, 0, 11, 1, 0, 1, "R10");
    // R6 freed unit reused
    step(1, 0, 0, 12, 0, 0, 1, "R10");
    idle(1, 0, 0, 1, "R6");
    // R4 out-of-range source
    step(1, 0, 3, 13, 0, 0, 1, "R4");
    idle(1, 0, 0, 1, "R4");

    // R8 all reservations full
    step(1, 0, 1, 14, 0, 0, 1, "R8");
    step(1, 0, 2, 15, 0, 0, 1, "R8");
    step(1, 0, 1, 1, 0, 0, 1, "R8");
    step(1, 0, 2, 2, 0, 0, 1, "R8");
    step(1, 0, 0, 3, 0, 0, 1, "R8");
    step(1, 1, 1, 4, 0, 1, 1, "R8");
    step(1, 1, 0, 5, 0, 1, 0, "R1");
    idle(1, 0, 1, 1, "R8");

    // drain everything
    idle(10, 1, 1, 1, "R2");
    chk(exp_req.size() == 0 && exp_rep.size() == 0, "R2", "scoreboard empty",
        exp_req.size() + exp_rep.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule